// File: doc/BRIEF.md
# Bitmap Glyph Character Renderer

This block turns one character command into a stream of pixel writes. A command holds a character code, a 10-bit x/y origin and a 24-bit colour, and it is taken on a valid/ready handshake. The block then reads a 64-bit glyph for that code from an external character ROM port with a fixed read latency. It loads the glyph into a shift register and walks the 8×8 cell one bit per clock. Each set bit produces a pixel word for a downstream FIFO. A clear bit produces nothing.

The walk is row-major and starts at the top-left pixel. It stops as soon as the bits still in the register are all zero, so a glyph whose last set bit is early finishes early. An all-zero glyph finishes with no pixels at all. While the FIFO reports full, the walk holds still. The ROM holds letters only, so any other code reads back as zero and draws nothing.

Top module: `glyph_render`

## Requirements
- R1: After reset, `cmd_ready` is 1, `pix_wr` is 0 and `rom_rd` is 0.
- R2: A command is accepted at a clock edge where `cmd_valid` and `cmd_ready` are both 1. In the next cycle, `rom_rd` is 1 for exactly one cycle, `rom_addr` equals the accepted `cmd_code` and `cmd_ready` is 0. The ROM returns the glyph on `rom_data` `ROM_LAT` clock edges after the edge that samples `rom_rd`, and holds it until the next read.
- R3: Glyph bit 63 is the top-left pixel. Scan position p (0..63) maps to bit 63-p, column p mod 8 and row p div 8, so the column wraps from 7 to 0 and then the row advances. Pixel writes come out in increasing p.
- R4: Each set bit emits one pixel with `pix_data` = {x[43:34], y[33:24], rgb[23:0]}. Here x = origin x + column and y = origin y + row, each modulo 1024, and rgb is the command colour. A clear bit emits nothing but still takes one clock.
- R5: When `pix_full` is 1 at the edge where the current bit is set, no write is launched and the scan position does not move. So `pix_wr` is 0 in the cycle after any edge that sampled `pix_full` high. The same pixel is written once space appears.
- R6: `cmd_ready` stays 0 while a character is being drawn. With no stalls, it is 0 for exactly ROM_LAT + 2 + n cycles after acceptance, where n is one plus the scan position of the last set bit. Every pixel write falls inside that window.
- R7: An all-zero glyph (for example a non-letter code) emits no pixel, and `cmd_ready` returns after ROM_LAT + 2 cycles.
- R8: `cmd_valid` while `cmd_ready` is 0 has no effect: no ROM read starts and the pixel stream of the current character is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_code | input | 8 | Character code |
| cmd_x | input | 10 | Cell origin x |
| cmd_y | input | 10 | Cell origin y |
| cmd_rgb | input | 24 | Pixel colour |
| rom_rd | output | 1 | Glyph ROM read strobe |
| rom_addr | output | 8 | Glyph ROM address (character code) |
| rom_data | input | 64 | Glyph ROM read data |
| pix_full | input | 1 | Downstream FIFO full |
| pix_wr | output | 1 | Pixel write strobe |
| pix_data | output | 44 | Pixel word {x, y, rgb} |

## Verification
A wrong shift or counter state shows up at the next emitted pixel. It appears as a wrong x or y in `pix_data`, or as a pixel that is missing or extra compared with the expected queue, so it is caught within one write. A wrong end-of-glyph decision shows up as a busy window whose length differs from ROM_LAT + 2 + n. A lost stall shows up as a write in the cycle after an edge that sampled `pix_full` high, or as a skipped pixel. A control fault that accepts commands while busy shows up as a second ROM read with a foreign address.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_FETCH = 2'd1,
    GS_SCAN  = 2'd2
  } glyph_state_e;
endpackage

// File: rtl/glyph_fetch.sv
module glyph_fetch
  import glyph_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int COORD_W = 10,
  parameter int RGB_W   = 24,
  parameter int ROM_LAT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic [COORD_W-1:0] cmd_x,
  input  logic [COORD_W-1:0] cmd_y,
  input  logic [RGB_W-1:0]   cmd_rgb,
  output logic               cmd_ready,
  output logic               rom_rd,
  output logic [CODE_W-1:0]  rom_addr,
  input  logic               done,
  output logic               load,
  output logic               scan_on,
  output logic [COORD_W-1:0] org_x,
  output logic [COORD_W-1:0] org_y,
  output logic [RGB_W-1:0]   org_rgb
);
  localparam int WC_W = $clog2(ROM_LAT + 1);

  glyph_state_e      state;
  logic [WC_W-1:0]   wcnt;

  assign load    = (state == GS_FETCH) && (wcnt == WC_W'(ROM_LAT));
  assign scan_on = (state == GS_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= GS_IDLE;
      cmd_ready <= 1'b1;
      rom_rd    <= 1'b0;
      rom_addr  <= '0;
      wcnt      <= '0;
      org_x     <= '0;
      org_y     <= '0;
      org_rgb   <= '0;
    end else begin
      rom_rd <= 1'b0;
      case (state)
        GS_IDLE: begin
          if (cmd_valid) begin
            org_x     <= cmd_x;
            org_y     <= cmd_y;
            org_rgb   <= cmd_rgb;
            rom_addr  <= cmd_code;
            rom_rd    <= 1'b1;
            cmd_ready <= 1'b0;
            wcnt      <= '0;
            state     <= GS_FETCH;
          end
        end
        GS_FETCH: begin
          if (load) state <= GS_SCAN;
          else      wcnt  <= wcnt + WC_W'(1);
        end
        GS_SCAN: begin
          if (done) begin
            state     <= GS_IDLE;
            cmd_ready <= 1'b1;
          end
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

  // R2: acceptance launches one ROM read and drops ready
  a_r2_accept_fetch: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (rom_rd && !cmd_ready));

  // R6: the end of the scan hands ready back on the next cycle
  a_r6_done_ready: assert property (@(posedge clk) disable iff (rst)
    done |=> cmd_ready);

  // R8: an offer while busy starts no read
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> !rom_rd);
endmodule

// File: rtl/glyph_shifter.sv
module glyph_shifter #(
  parameter int BITS = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] rom_data,
  input  logic            scan_on,
  input  logic            pix_full,
  output logic            step,
  output logic            emit,
  output logic            done
);
  logic [BITS-1:0] shreg;
  logic            msb;
  logic            empty;

  assign msb   = shreg[BITS-1];
  assign empty = (shreg == '0);
  assign step  = scan_on && !empty && (!msb || !pix_full);
  assign emit  = scan_on && !empty && msb && !pix_full;
  assign done  = scan_on && empty;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= rom_data;
    else if (step) shreg <= {shreg[BITS-2:0], 1'b0};
  end

  // R7: a glyph loaded as zero finishes on the first scan cycle
  a_r7_zero_done: assert property (@(posedge clk) disable iff (rst)
    (load && rom_data == '0) |=> done);
endmodule

// File: rtl/glyph_cursor.sv
module glyph_cursor #(
  parameter int SIDE    = 8,
  parameter int COORD_W = 10,
  parameter int RGB_W   = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       step,
  input  logic                       emit,
  input  logic                       pix_full,
  input  logic [COORD_W-1:0]         org_x,
  input  logic [COORD_W-1:0]         org_y,
  input  logic [RGB_W-1:0]           org_rgb,
  output logic                       pix_wr,
  output logic [2*COORD_W+RGB_W-1:0] pix_data
);
  localparam int OFF_W = (SIDE > 1) ? $clog2(SIDE) : 1;

  logic [OFF_W-1:0]   col;
  logic [OFF_W-1:0]   row;
  logic [COORD_W-1:0] px;
  logic [COORD_W-1:0] py;

  assign px = org_x + COORD_W'(col);
  assign py = org_y + COORD_W'(row);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (load) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (col == OFF_W'(SIDE - 1)) begin
        col <= '0;
        row <= row + OFF_W'(1);
      end else begin
        col <= col + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_wr   <= 1'b0;
      pix_data <= '0;
    end else begin
      pix_wr <= emit;
      if (emit) pix_data <= {px, py, org_rgb};
    end
  end

  // R5: no write is launched from an edge that saw the FIFO full
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
    pix_full |=> !pix_wr);
endmodule

// File: rtl/glyph_render.sv
module glyph_render #(
  parameter int CODE_W  = 8,
  parameter int COORD_W = 10,
  parameter int RGB_W   = 24,
  parameter int SIDE    = 8,
  parameter int ROM_LAT = 2,
  localparam int BITS   = SIDE * SIDE,
  localparam int PIX_W  = 2 * COORD_W + RGB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic [COORD_W-1:0] cmd_x,
  input  logic [COORD_W-1:0] cmd_y,
  input  logic [RGB_W-1:0]   cmd_rgb,
  output logic               rom_rd,
  output logic [CODE_W-1:0]  rom_addr,
  input  logic [BITS-1:0]    rom_data,
  input  logic               pix_full,
  output logic               pix_wr,
  output logic [PIX_W-1:0]   pix_data
);
  logic               load;
  logic               scan_on;
  logic               step;
  logic               emit;
  logic               done;
  logic [COORD_W-1:0] org_x;
  logic [COORD_W-1:0] org_y;
  logic [RGB_W-1:0]   org_rgb;

  glyph_fetch #(
    .CODE_W(CODE_W), .COORD_W(COORD_W), .RGB_W(RGB_W), .ROM_LAT(ROM_LAT)
  ) u_fetch (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_rgb(cmd_rgb), .cmd_ready(cmd_ready),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .done(done), .load(load),
    .scan_on(scan_on), .org_x(org_x), .org_y(org_y), .org_rgb(org_rgb)
  );

  glyph_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst(rst), .load(load), .rom_data(rom_data),
    .scan_on(scan_on), .pix_full(pix_full), .step(step), .emit(emit),
    .done(done)
  );

  glyph_cursor #(.SIDE(SIDE), .COORD_W(COORD_W), .RGB_W(RGB_W)) u_cursor (
    .clk(clk), .rst(rst), .load(load), .step(step), .emit(emit),
    .pix_full(pix_full), .org_x(org_x), .org_y(org_y), .org_rgb(org_rgb),
    .pix_wr(pix_wr), .pix_data(pix_data)
  );

  // R6: every pixel write falls inside the busy window
  a_r6_write_busy: assert property (@(posedge clk) disable iff (rst)
    pix_wr |-> !cmd_ready);
endmodule

// File: tb/tb_glyph_render.sv
module tb_glyph_render;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_code = 8'd0;
  logic [9:0]  cmd_x = 10'd0;
  logic [9:0]  cmd_y = 10'd0;
  logic [23:0] cmd_rgb = 24'd0;
  logic        rom_rd;
  logic [7:0]  rom_addr;
  logic [63:0] rom_data = 64'd0;
  logic [63:0] rom_q1 = 64'd0;
  logic        pix_full = 1'b0;
  logic        pix_wr;
  logic [43:0] pix_data;

  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          rd_cnt = 0;
  logic [7:0]  exp_code = 8'd0;
  bit          stall_en = 1'b0;
  logic        full_s = 1'b0;
  logic [43:0] exp_q[$];

  glyph_render #(.ROM_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_rgb(cmd_rgb),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .pix_full(pix_full), .pix_wr(pix_wr), .pix_data(pix_data)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] glyph(input logic [7:0] c);
    if (c == "A") return 64'h3844_4444_7C44_4400;
    if (c == "I") return 64'h8000_0000_0000_0000;
    if (c == "J") return 64'h0000_0000_0000_0001;
    if (c == "z") return {64{1'b1}};
    if ((c >= "A" && c <= "Z") || (c >= "a" && c <= "z")) return {8{c}};
    return 64'd0;
  endfunction

  // ROM model: data valid LAT edges after the sampling edge
  always @(posedge clk) begin
    if (rom_rd) rom_q1 <= glyph(rom_addr);
    rom_data <= rom_q1;
    full_s   <= pix_full;
  end

  task automatic check(input bit ok, input string req, input longint act,
                       input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // stall pattern and output monitor, away from the active edge
  always @(negedge clk) begin
    pix_full = stall_en && (cyc % 3 == 0);
    if (!rst) begin
      if (rom_rd) begin
        rd_cnt++;
        check(rom_addr == exp_code, "R2 rom_addr", rom_addr, exp_code);
      end
      if (pix_wr) begin
        check(!full_s, "R5 write after full", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected pixel", pix_data, 0);
        end else begin
          check(pix_data == exp_q[0], "R3 R4 pixel word", pix_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic draw(input logic [7:0] code, input logic [9:0] x,
                      input logic [9:0] y, input logic [23:0] rgb,
                      input bit stall, input bit inject, input string req);
    logic [63:0] g;
    int          n;
    int          busy;
    int          rd0;
    g = glyph(code);
    n = 0;
    for (int p = 0; p < 64; p++) begin
      if (g[63-p]) begin
        n = p + 1;
        exp_q.push_back({x + 10'(p % 8), y + 10'(p / 8), rgb});
      end
    end
    exp_code = code;
    rd0 = rd_cnt;
    stall_en = stall;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_x = x; cmd_y = y; cmd_rgb = rgb;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rom_rd == 1'b1, "R2 rom_rd pulse", rom_rd, 1);
    busy = 0;
    while (cmd_ready == 1'b0 && busy < 3000) begin
      busy++;
      if (inject && busy == 10) begin
        cmd_valid = 1'b1; cmd_code = "B"; cmd_x = 10'd5; cmd_y = 10'd5;
      end
      if (inject && busy == 13) cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    stall_en = 1'b0;
    if (stall)
      check(busy > LAT + 2 + n, {req, " busy with stalls"}, busy, LAT + 2 + n);
    else
      check(busy == LAT + 2 + n, {req, " busy length"}, busy, LAT + 2 + n);
    check(exp_q.size() == 0, {req, " pixels left"}, exp_q.size(), 0);
    repeat (4) @(negedge clk);
    check(rd_cnt == rd0 + 1, {req, " rom reads"}, rd_cnt - rd0, 1);
    check(cmd_ready == 1'b1, {req, " ready idle"}, cmd_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(pix_wr == 1'b0, "R1 pix_wr", pix_wr, 0);
    check(rom_rd == 1'b0, "R1 rom_rd", rom_rd, 0);

    draw("A", 10'd100, 10'd50, 24'h00FF00, 1'b0, 1'b0, "R3 R4 R6 glyph A");
    draw("I", 10'd0, 10'd0, 24'h123456, 1'b0, 1'b0, "R6 early end");
    draw("J", 10'd7, 10'd9, 24'hABCDEF, 1'b0, 1'b0, "R3 R6 last bit");
    draw("?", 10'd3, 10'd3, 24'hFFFFFF, 1'b0, 1'b0, "R7 zero glyph");
    draw("g", 10'd1020, 10'd1021, 24'h0000FF, 1'b0, 1'b0, "R4 wrap");
    draw("z", 10'd200, 10'd300, 24'hFF0000, 1'b1, 1'b0, "R5 stall");
    draw("z", 10'd40, 10'd60, 24'h00AAAA, 1'b0, 1'b1, "R8 ignored offer");
    draw("q", 10'd512, 10'd256, 24'h777777, 1'b1, 1'b0, "R5 R3 stall q");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule